// File: doc/BRIEF.md
# Debug port JTAG instruction decoder

This block holds the instruction register of a JTAG debug port and turns the current instruction into a choice of data register. It sits beside a standard TAP state machine and is driven by that machine's per-state strobes. The strobes mark the reset state, the three IR states (capture, shift, update) and the three DR states (capture, shift, update). All strobes are sampled on the rising edge of TCK. A 4-bit shift stage moves serially between TDI and TDO. A 4-bit current instruction is loaded from the shift stage only on the update strobe.

From the current instruction the block drives one-hot select lines for the access, abort, identification and bypass registers, and the DR scan length that the selected register expects. The contents of the abort, access and identification registers live elsewhere; only their serial outputs come in. The 1-bit bypass register is built in. A falling-edge output stage picks which serial source drives TDO, and drives TDO low with its enable low outside the two shift states.

The shift-stage controller works on five named operations. Their priority is: reset, then capture, then shift, then update, then hold. **Reset** loads the identification code. **Capture** loads the constant `0001`. **Shift** moves one bit in at the top and one bit out at the bottom. **Update** copies the shift stage into the current instruction. **Hold** keeps both registers. The decoder maps every current instruction onto one of five selection states. These are bypass, abort, debug-port access, access-port access and identification. The selection changes only on the reset or update operation.

Top module: `dbgport_ir_select`

## Requirements
- R1: On a capture-IR cycle the shift stage loads binary `0001`. The following four shift-IR cycles present it on TDO least significant bit first, so the readback is 1, 0, 0, 0.
- R2: Shift-IR takes TDI into the shift stage least significant bit first. Only an update-IR cycle copies the shift stage into the current instruction. The select lines and length stay unchanged through capture, shift and the update cycle itself, and take the new value one TCK later.
- R3: A test-logic-reset cycle makes the identification code `1110` current, which gives `sel_idcode_o`=1 and `dr_len_o`=32. Reset wins over an update-IR strobe in the same cycle.
- R4: The code `1000` selects abort, `1010` selects debug-port access and `1011` selects access-port access, each with `dr_len_o`=35. The code `1110` selects identification with `dr_len_o`=32. Exactly one select line is high at all times.
- R5: Every other code, `0000`–`0111`, `1001`, `1100`, `1101` and `1111`, selects bypass with `dr_len_o`=1.
- R6: With bypass selected, capture-DR clears the bypass bit. Shift-DR then returns on TDO the TDI bit of the previous shift cycle, with exactly one TCK of delay. The first bit out after capture is 0.
- R7: With bypass selected, an update-DR cycle leaves the bypass bit unchanged.
- R8: During shift-DR, TDO carries the serial output of the register selected by the current instruction.
- R9: TDO and `tdo_en_o` change on the falling edge of TCK. Outside shift-IR and shift-DR, `tdo_en_o` is 0 and TDO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tlr_i | input | 1 | TAP in test-logic-reset |
| capture_ir_i | input | 1 | TAP in capture-IR |
| shift_ir_i | input | 1 | TAP in shift-IR |
| update_ir_i | input | 1 | TAP in update-IR |
| capture_dr_i | input | 1 | TAP in capture-DR |
| shift_dr_i | input | 1 | TAP in shift-DR |
| update_dr_i | input | 1 | TAP in update-DR |
| tdi_i | input | 1 | Serial test data in |
| abort_so_i | input | 1 | Abort register serial out |
| dpacc_so_i | input | 1 | Debug-port access register serial out |
| apacc_so_i | input | 1 | Access-port access register serial out |
| idcode_so_i | input | 1 | Identification register serial out |
| tdo_o | output | 1 | Serial test data out |
| tdo_en_o | output | 1 | TDO drive enable |
| sel_abort_o | output | 1 | Abort register selected |
| sel_dpacc_o | output | 1 | Debug-port access selected |
| sel_apacc_o | output | 1 | Access-port access selected |
| sel_idcode_o | output | 1 | Identification selected |
| sel_bypass_o | output | 1 | Bypass selected |
| dr_len_o | output | 6 | DR scan length of the selected register |

## Verification
A correct TAP never raises the reset and update-IR strobes together. A glitching state decoder can, and then the instruction register must settle on the identification code, not on the shifted word. The bench shifts in the abort code and raises both strobes in the update cycle. One TCK later it expects the identification select and a length of 32. An assertion also checks that every cycle leaving reset shows the identification selection.

// File: rtl/dp_ir_pkg.sv
package dp_ir_pkg;
    localparam int IR_W   = 4;
    localparam int LEN_W  = 6;
    localparam int NSEL   = 5;

    localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;
    localparam logic [IR_W-1:0] CODE_ABORT  = 4'b1000;
    localparam logic [IR_W-1:0] CODE_DPACC  = 4'b1010;
    localparam logic [IR_W-1:0] CODE_APACC  = 4'b1011;
    localparam logic [IR_W-1:0] CODE_IDCODE = 4'b1110;

    localparam logic [LEN_W-1:0] LEN_ACC = 6'd35;
    localparam logic [LEN_W-1:0] LEN_ID  = 6'd32;
    localparam logic [LEN_W-1:0] LEN_BYP = 6'd1;

    typedef enum logic [2:0] {
        DR_BYPASS = 3'd0,
        DR_ABORT  = 3'd1,
        DR_DPACC  = 3'd2,
        DR_APACC  = 3'd3,
        DR_IDCODE = 3'd4
    } dr_sel_e;

    typedef enum logic [2:0] {
        IR_HOLD, IR_RESET, IR_CAPT, IR_SHIFT, IR_UPDATE
    } ir_op_e;

    typedef enum logic [1:0] {
        BY_HOLD, BY_RESET, BY_CAPT, BY_SHIFT
    } by_op_e;
endpackage

// File: rtl/dp_ir_reg.sv
module dp_ir_reg
    import dp_ir_pkg::*;
(
    input  logic            tck,
    input  logic            tlr,
    input  logic            cap,
    input  logic            shf,
    input  logic            upd,
    input  logic            tdi,
    output logic [IR_W-1:0] sh_q,
    output logic [IR_W-1:0] cur_q
);
    ir_op_e op;

    // operation priority: reset > capture > shift > update > hold
    always_comb begin
        if (tlr)      op = IR_RESET;
        else if (cap) op = IR_CAPT;
        else if (shf) op = IR_SHIFT;
        else if (upd) op = IR_UPDATE;
        else          op = IR_HOLD;
    end

    always_ff @(posedge tck) begin
        unique case (op)
            IR_RESET: begin
                sh_q  <= IR_CAPTURE;
                cur_q <= CODE_IDCODE;
            end
            IR_CAPT:   sh_q  <= IR_CAPTURE;
            IR_SHIFT:  sh_q  <= {tdi, sh_q[IR_W-1:1]};
            IR_UPDATE: cur_q <= sh_q;
            default: ;
        endcase
    end
endmodule

// File: rtl/dp_ir_decode.sv
module dp_ir_decode
    import dp_ir_pkg::*;
(
    input  logic [IR_W-1:0]  cur,
    output dr_sel_e          sel,
    output logic [NSEL-1:0]  onehot,
    output logic [LEN_W-1:0] len
);
    always_comb begin
        unique case (cur)
            CODE_ABORT:  sel = DR_ABORT;
            CODE_DPACC:  sel = DR_DPACC;
            CODE_APACC:  sel = DR_APACC;
            CODE_IDCODE: sel = DR_IDCODE;
            default:     sel = DR_BYPASS;
        endcase
    end

    always_comb begin
        unique case (sel)
            DR_ABORT, DR_DPACC, DR_APACC: len = LEN_ACC;
            DR_IDCODE:                    len = LEN_ID;
            default:                      len = LEN_BYP;
        endcase
    end

    for (genvar g = 0; g < NSEL; g++) begin : g_sel
        assign onehot[g] = (sel == dr_sel_e'(g));
    end
endmodule

// File: rtl/dp_bypass_cell.sv
module dp_bypass_cell
    import dp_ir_pkg::*;
(
    input  logic tck,
    input  logic tlr,
    input  logic cap,
    input  logic shf,
    input  logic upd,
    input  logic active,
    input  logic tdi,
    output logic byp_q
);
    by_op_e op;

    always_comb begin
        if (tlr)                   op = BY_RESET;
        else if (!active || upd)   op = BY_HOLD;
        else if (cap)              op = BY_CAPT;
        else if (shf)              op = BY_SHIFT;
        else                       op = BY_HOLD;
    end

    always_ff @(posedge tck) begin
        unique case (op)
            BY_RESET, BY_CAPT: byp_q <= 1'b0;
            BY_SHIFT:          byp_q <= tdi;
            default: ;
        endcase
    end
endmodule

// File: rtl/dp_tdo_out.sv
module dp_tdo_out (
    input  logic tck,
    input  logic sir,
    input  logic sdr,
    input  logic ir_so,
    input  logic dr_so,
    output logic tdo,
    output logic tdo_en
);
    always_ff @(negedge tck) begin
        tdo_en <= sir | sdr;
        if (sir)      tdo <= ir_so;
        else if (sdr) tdo <= dr_so;
        else          tdo <= 1'b0;
    end
endmodule

// File: rtl/dbgport_ir_select.sv
module dbgport_ir_select
    import dp_ir_pkg::*;
(
    input  logic             tck,
    input  logic             tlr_i,
    input  logic             capture_ir_i,
    input  logic             shift_ir_i,
    input  logic             update_ir_i,
    input  logic             capture_dr_i,
    input  logic             shift_dr_i,
    input  logic             update_dr_i,
    input  logic             tdi_i,
    input  logic             abort_so_i,
    input  logic             dpacc_so_i,
    input  logic             apacc_so_i,
    input  logic             idcode_so_i,
    output logic             tdo_o,
    output logic             tdo_en_o,
    output logic             sel_abort_o,
    output logic             sel_dpacc_o,
    output logic             sel_apacc_o,
    output logic             sel_idcode_o,
    output logic             sel_bypass_o,
    output logic [LEN_W-1:0] dr_len_o
);
    logic [IR_W-1:0] ir_sh;
    logic [IR_W-1:0] ir_cur;
    dr_sel_e         sel;
    logic [NSEL-1:0] sel_vec;
    logic            byp_q;
    logic            dr_so;

    dp_ir_reg u_ir (
        .tck(tck), .tlr(tlr_i), .cap(capture_ir_i), .shf(shift_ir_i),
        .upd(update_ir_i), .tdi(tdi_i), .sh_q(ir_sh), .cur_q(ir_cur)
    );

    dp_ir_decode u_dec (
        .cur(ir_cur), .sel(sel), .onehot(sel_vec), .len(dr_len_o)
    );

    dp_bypass_cell u_byp (
        .tck(tck), .tlr(tlr_i), .cap(capture_dr_i), .shf(shift_dr_i),
        .upd(update_dr_i), .active(sel_vec[DR_BYPASS]), .tdi(tdi_i),
        .byp_q(byp_q)
    );

    always_comb begin
        unique case (sel)
            DR_ABORT:  dr_so = abort_so_i;
            DR_DPACC:  dr_so = dpacc_so_i;
            DR_APACC:  dr_so = apacc_so_i;
            DR_IDCODE: dr_so = idcode_so_i;
            default:   dr_so = byp_q;
        endcase
    end

    dp_tdo_out u_tdo (
        .tck(tck), .sir(shift_ir_i), .sdr(shift_dr_i), .ir_so(ir_sh[0]),
        .dr_so(dr_so), .tdo(tdo_o), .tdo_en(tdo_en_o)
    );

    assign sel_bypass_o = sel_vec[DR_BYPASS];
    assign sel_abort_o  = sel_vec[DR_ABORT];
    assign sel_dpacc_o  = sel_vec[DR_DPACC];
    assign sel_apacc_o  = sel_vec[DR_APACC];
    assign sel_idcode_o = sel_vec[DR_IDCODE];
endmodule

// File: rtl/dp_ir_sva.sv
module dp_ir_sva (
    input logic       tck,
    input logic       tlr_i,
    input logic       update_ir_i,
    input logic       shift_ir_i,
    input logic       shift_dr_i,
    input logic       tdo_o,
    input logic       tdo_en_o,
    input logic       sel_abort_o,
    input logic       sel_dpacc_o,
    input logic       sel_apacc_o,
    input logic       sel_idcode_o,
    input logic       sel_bypass_o,
    input logic [5:0] dr_len_o
);
    logic [4:0] sels;
    assign sels = {sel_idcode_o, sel_apacc_o, sel_dpacc_o, sel_abort_o, sel_bypass_o};

    p_sel_onehot_r4: assert property (@(posedge tck) disable iff (tlr_i)
        $countones(sels) == 1);

    p_acc_len_r4: assert property (@(posedge tck) disable iff (tlr_i)
        (sel_abort_o || sel_dpacc_o || sel_apacc_o) |-> dr_len_o == 6'd35);

    p_bypass_len_r5: assert property (@(posedge tck) disable iff (tlr_i)
        sel_bypass_o |-> dr_len_o == 6'd1);

    p_reset_to_idcode_r3: assert property (@(posedge tck) disable iff (tlr_i)
        $past(tlr_i) |-> (sel_idcode_o && dr_len_o == 6'd32));

    p_hold_until_update_r2: assert property (@(posedge tck) disable iff (tlr_i)
        (!$past(update_ir_i) && !$past(tlr_i)) |-> $stable(sels));

    p_idle_tdo_r9: assert property (@(posedge tck) disable iff (tlr_i)
        (!shift_ir_i && !shift_dr_i) |-> (!tdo_en_o && !tdo_o));
endmodule

bind dbgport_ir_select dp_ir_sva u_sva (
    .tck(tck), .tlr_i(tlr_i), .update_ir_i(update_ir_i),
    .shift_ir_i(shift_ir_i), .shift_dr_i(shift_dr_i),
    .tdo_o(tdo_o), .tdo_en_o(tdo_en_o),
    .sel_abort_o(sel_abort_o), .sel_dpacc_o(sel_dpacc_o),
    .sel_apacc_o(sel_apacc_o), .sel_idcode_o(sel_idcode_o),
    .sel_bypass_o(sel_bypass_o), .dr_len_o(dr_len_o)
);

// File: tb/dbgport_ir_select_tb.sv
module dbgport_ir_select_tb_top;
    localparam int TCK_PERIOD = 20;

    // strobe word {tlr, cap_ir, sh_ir, upd_ir, cap_dr, sh_dr, upd_dr}
    localparam logic [6:0] S_IDLE = 7'b0000000;
    localparam logic [6:0] S_TLR  = 7'b1000000;
    localparam logic [6:0] S_CIR  = 7'b0100000;
    localparam logic [6:0] S_SIR  = 7'b0010000;
    localparam logic [6:0] S_UIR  = 7'b0001000;
    localparam logic [6:0] S_CDR  = 7'b0000100;
    localparam logic [6:0] S_SDR  = 7'b0000010;
    localparam logic [6:0] S_UDR  = 7'b0000001;

    // expected {sel_bypass, sel_idcode, sel_apacc, sel_dpacc, sel_abort, len[5:0]} per code
    localparam logic [10:0] VEC [0:15] = '{
        {5'b10000, 6'd1}, {5'b10000, 6'd1}, {5'b10000, 6'd1}, {5'b10000, 6'd1},
        {5'b10000, 6'd1}, {5'b10000, 6'd1}, {5'b10000, 6'd1}, {5'b10000, 6'd1},
        {5'b00001, 6'd35}, {5'b10000, 6'd1}, {5'b00010, 6'd35}, {5'b00100, 6'd35},
        {5'b10000, 6'd1}, {5'b10000, 6'd1}, {5'b01000, 6'd32}, {5'b10000, 6'd1}
    };

    logic tck = 1'b0;
    logic tlr = 1'b1, cir = 1'b0, sir = 1'b0, uir = 1'b0;
    logic cdr = 1'b0, sdr = 1'b0, udr = 1'b0, tdi = 1'b0;
    logic abort_so = 1'b0, dpacc_so = 1'b0, apacc_so = 1'b0, idcode_so = 1'b0;
    logic tdo, tdo_en;
    logic s_abort, s_dpacc, s_apacc, s_idcode, s_bypass;
    logic [5:0] dr_len;
    logic [4:0] sel_vec;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    assign sel_vec = {s_bypass, s_idcode, s_apacc, s_dpacc, s_abort};

    always #(TCK_PERIOD/2) tck = ~tck;

    dbgport_ir_select dut_i (
        .tck(tck), .tlr_i(tlr), .capture_ir_i(cir), .shift_ir_i(sir),
        .update_ir_i(uir), .capture_dr_i(cdr), .shift_dr_i(sdr),
        .update_dr_i(udr), .tdi_i(tdi), .abort_so_i(abort_so),
        .dpacc_so_i(dpacc_so), .apacc_so_i(apacc_so), .idcode_so_i(idcode_so),
        .tdo_o(tdo), .tdo_en_o(tdo_en), .sel_abort_o(s_abort),
        .sel_dpacc_o(s_dpacc), .sel_apacc_o(s_apacc), .sel_idcode_o(s_idcode),
        .sel_bypass_o(s_bypass), .dr_len_o(dr_len)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive a cycle just after the rising edge, return just after the falling edge
    task automatic cyc(input logic [6:0] st, input logic d);
        @(posedge tck); #1;
        {tlr, cir, sir, uir, cdr, sdr, udr} = st;
        tdi = d;
        @(negedge tck); #1;
    endtask

    task automatic load_ir(input logic [3:0] code, input logic [4:0] prev_sel,
                           output logic [3:0] rb);
        cyc(S_CIR, 1'b0);
        chk("R2 select held in capture-IR", {27'd0, sel_vec}, {27'd0, prev_sel});
        for (int j = 0; j < 4; j++) begin
            cyc(S_SIR, code[j]);
            rb[j] = tdo;
            chk("R9 tdo_en in shift-IR", {31'd0, tdo_en}, 32'd1);
        end
        chk("R2 select held in shift-IR", {27'd0, sel_vec}, {27'd0, prev_sel});
        cyc(S_UIR, 1'b0);
        chk("R2 select held in update cycle", {27'd0, sel_vec}, {27'd0, prev_sel});
        cyc(S_IDLE, 1'b0);
    endtask

    initial begin
        #(TCK_PERIOD * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] prev_sel;
        logic [3:0] rb;
        logic       prev_bit;
        logic       b;

        // reset state
        cyc(S_TLR, 1'b0);
        cyc(S_TLR, 1'b0);
        cyc(S_IDLE, 1'b0);
        chk("R3 reset selects identification", {27'd0, sel_vec}, 32'h08);
        chk("R3 reset length 32", {26'd0, dr_len}, 32'd32);
        chk("R9 idle tdo_en low", {31'd0, tdo_en}, 32'd0);
        chk("R9 idle tdo low", {31'd0, tdo}, 32'd0);
        prev_sel = 5'b01000;

        // every code: capture readback, decode, DR mux
        for (int c = 0; c < 16; c++) begin
            load_ir(4'(c), prev_sel, rb);
            chk("R1 capture readback 0001", {28'd0, rb}, 32'h1);
            if (VEC[c][10])
                chk("R5 bypass fallback select", {27'd0, sel_vec}, {27'd0, VEC[c][10:6]});
            else
                chk("R4 decoded select", {27'd0, sel_vec}, {27'd0, VEC[c][10:6]});
            chk("R4 R5 scan length", {26'd0, dr_len}, {26'd0, VEC[c][5:0]});
            if (!VEC[c][10]) begin
                {idcode_so, apacc_so, dpacc_so, abort_so} = VEC[c][9:6];
                cyc(S_CDR, 1'b0);
                cyc(S_SDR, 1'b0);
                chk("R8 selected serial out high", {31'd0, tdo}, 32'd1);
                {idcode_so, apacc_so, dpacc_so, abort_so} = ~VEC[c][9:6];
                cyc(S_SDR, 1'b1);
                chk("R8 selected serial out low", {31'd0, tdo}, 32'd0);
                cyc(S_UDR, 1'b0);
                chk("R9 tdo_en low in update-DR", {31'd0, tdo_en}, 32'd0);
                {idcode_so, apacc_so, dpacc_so, abort_so} = 4'b0000;
            end
            prev_sel = VEC[c][10:6];
        end

        // reset and update-IR in the same cycle: reset wins
        load_ir(4'b1000, prev_sel, rb);
        chk("R4 abort loaded before collision", {27'd0, sel_vec}, 32'h01);
        cyc(S_CIR, 1'b0);
        for (int j = 0; j < 4; j++) cyc(S_SIR, j == 3);
        cyc(S_TLR | S_UIR, 1'b0);
        cyc(S_IDLE, 1'b0);
        chk("R3 reset wins over update-IR", {27'd0, sel_vec}, 32'h08);
        chk("R3 length after collision", {26'd0, dr_len}, 32'd32);

        // bypass over a random stream
        load_ir(4'b0011, 5'b01000, rb);
        chk("R5 reserved code selects bypass", {27'd0, sel_vec}, 32'h10);
        cyc(S_CDR, 1'b0);
        prev_bit = 1'b0;
        for (int k = 0; k < 48; k++) begin
            b = (k == 47) ? 1'b1 : 1'($urandom);
            cyc(S_SDR, b);
            chk("R6 one-cycle bypass delay", {31'd0, tdo}, {31'd0, prev_bit});
            prev_bit = b;
        end
        cyc(S_UDR, 1'b0);
        cyc(S_SDR, 1'b0);
        chk("R7 update-DR keeps bypass bit", {31'd0, tdo}, 32'd1);
        cyc(S_CDR, 1'b0);
        cyc(S_SDR, 1'b1);
        chk("R6 capture-DR clears bypass bit", {31'd0, tdo}, 32'd0);
        cyc(S_IDLE, 1'b1);
        chk("R9 idle tdo low after shift", {31'd0, tdo}, 32'd0);

        // falling-edge timing: shift one more, check TDO before and after falling edge
        cyc(S_SDR, 1'b1);
        @(posedge tck); #1;
        {tlr, cir, sir, uir, cdr, sdr, udr} = S_IDLE;
        chk("R9 tdo holds until falling edge", {31'd0, tdo_en}, 32'd1);
        @(negedge tck); #1;
        chk("R9 tdo_en drops at falling edge", {31'd0, tdo_en}, 32'd0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule